// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Unit

This block is the control front end of a pipelined synchronous burst SRAM. On every rising clock edge it samples three chip enables, two active-low address strobes (one meant for a processor, one for a memory controller), an active-low advance input and an active-low write enable. A strobe that finds the device selected captures the address. The two low address bits are loaded into a burst counter. Later advance cycles step that counter through the other words of the four-word group.

Reads are pipelined through one output register. The data for an address sampled at one edge appears on the output after that same edge. The tri-state data bus is modelled as a data output plus a drive flag. The drive flag follows the asynchronous active-low output enable, but only while a read burst is in progress. A sleep input freezes all activity and leaves the array contents intact.

The sequencer has four states:
- `ST_DESEL`: deselected; the output is never driven.
- `ST_READ`: a read burst.
- `ST_WRITE`: a write burst.
- `ST_SLEEP`: low-activity hold.

Its transitions are:
- **select-read** and **select-write**: a qualified strobe with the device selected enters `ST_READ` or `ST_WRITE`, chosen by the write enable.
- **deselect**: a qualified strobe with the device not selected enters `ST_DESEL`.
- **advance-read** and **advance-write**: an advance inside a burst moves to `ST_READ` or `ST_WRITE`, chosen by the write enable.
- **suspend**: with no strobe and the advance input high, the state is kept.
- **doze**: sleep high enters `ST_SLEEP` from any state.
- **wake**: leaving sleep without a strobe enters `ST_DESEL`.

Top module: `sram_burst_ctl`

## Requirements
- R1: While reset is low and after it is released, the block is deselected, and `dq_drive` and `dq_out` are 0 even with `oe_n` low.
- R2: A qualified strobe selects the device only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. Any other chip-enable combination deselects it, and `dq_drive` is 0 after that edge.
- R3: The processor strobe `astb_p_n` is ignored while `cs1_n` is 1. In that case a burst in progress continues, and an advance in the same cycle still takes effect. When both strobes are low in one cycle, only the processor strobe is acted on. If it is ignored, the controller strobe acts instead.
- R4: A selected strobe loads `addr[1:0]` into the burst counter and keeps `addr[AW-1:2]`. Each advance cycle (`adv_n`=0, no strobe) inside a burst adds 1 to the counter modulo 4, wrapping from 3 to 0. The word address is then {captured upper bits, counter}.
- R5: With no strobe and `adv_n`=1, the burst counter holds. A read burst keeps presenting the same word.
- R6: The data for the address used at a read edge is on `dq_out` immediately after that edge: one register of read latency.
- R7: With `we_n`=0 at a selected strobe or an advance, `dq_in` is stored at that edge into the addressed word, and the burst becomes a write burst.
- R8: `dq_drive` is 1 only in a read burst with `oe_n`=0, and it follows `oe_n` without waiting for a clock. It stays 0 during a write burst and during the strobe cycle that leaves the deselected state.
- R9: While `sleep` is 1, strobes, advances and writes are ignored and `dq_drive` is 0. Stored data is kept. After `sleep` returns to 0, the block is deselected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs1_n | input | 1 | Chip enable 1, active low; also qualifies the processor strobe |
| cs2 | input | 1 | Chip enable 2, active high |
| cs3_n | input | 1 | Chip enable 3, active low |
| astb_p_n | input | 1 | Processor address strobe, active low, higher priority |
| astb_c_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| we_n | input | 1 | Write enable, active low, sampled with strobe or advance |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| sleep | input | 1 | Sleep request, active high |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data toward the bus, 0 when not driven |
| dq_drive | output | 1 | Bus drive enable (tri-state control) |

## Verification
The hardest situation to reach from the ports is a processor strobe that arrives with `cs1_n` high in the middle of a read burst. It must vanish without trace while an advance in the same cycle still steps the counter. The bench opens a burst, then presents exactly that combination with a different address on the bus. It confirms that the next word of the original burst appears. It then repeats the cycle with both strobes low and confirms that the controller strobe takes over and deselects the device.

The masked first cycle out of the deselected state is reached by forcing a deselect first. The bench then looks at the drive flag during the new strobe cycle, before the clock edge.

The address-order rule is swept over every base address and every starting offset. Each burst is advanced through five words, so the wrap back to the starting word is also seen.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } sbc_state_t;
endpackage

// File: rtl/sbc_strobe_dec.sv
module sbc_strobe_dec (
    input  logic cs1_n,
    input  logic cs2,
    input  logic cs3_n,
    input  logic astb_p_n,
    input  logic astb_c_n,
    output logic start,
    output logic sel
);
    logic proc_ok;
    logic ctrl_ok;

    always_comb begin
        // Processor strobe only counts while chip enable 1 is low.
        proc_ok = !astb_p_n && !cs1_n;
        // Controller strobe acts only when no processor strobe is acted on.
        ctrl_ok = !astb_c_n && !proc_ok;
        start   = proc_ok || ctrl_ok;
        sel     = !cs1_n && cs2 && !cs3_n;
    end
endmodule

// File: rtl/sbc_burst_addr.sv
module sbc_burst_addr #(
    parameter int AW = 6,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] eff_addr
);
    localparam int HW = AW - BW;

    logic [HW-1:0] hi_q;
    logic [BW-1:0] cnt_q;
    logic [BW-1:0] cnt_nx;

    always_comb begin
        if (load) begin
            cnt_nx   = addr_in[BW-1:0];
            eff_addr = addr_in;
        end else begin
            cnt_nx   = adv ? cnt_q + BW'(1) : cnt_q;
            eff_addr = {hi_q, cnt_nx};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (load) hi_q <= addr_in[AW-1:BW];
            cnt_q <= cnt_nx;
        end
    end

    // R4: a load takes the low address bits
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(addr_in[BW-1:0]));
    // R4: an advance steps by one, wrapping modulo the burst length
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> cnt_q == $past(cnt_q) + BW'(1));
    // R5: no load and no advance keeps the burst position
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> ($stable(cnt_q) && $stable(hi_q)));
endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[addr];
    end

    assign rdata = rd_q;

    // R7: a cycle is either a read or a write, never both
    a_r7_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));
endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
    import sbc_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          astb_p_n,
    input  logic          astb_c_n,
    input  logic          adv_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_drive
);
    localparam int BURST_BITS = 2;

    sbc_state_t    state_q;
    sbc_state_t    state_nx;
    logic          start;
    logic          sel;
    logic          load;
    logic          adv_go;
    logic          hold_rd;
    logic          arr_wr;
    logic          arr_rd;
    logic          in_burst;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] rd_data;

    sbc_strobe_dec u_dec (
        .cs1_n    (cs1_n),
        .cs2      (cs2),
        .cs3_n    (cs3_n),
        .astb_p_n (astb_p_n),
        .astb_c_n (astb_c_n),
        .start    (start),
        .sel      (sel)
    );

    sbc_burst_addr #(.AW(AW), .BW(BURST_BITS)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv_go),
        .addr_in  (addr),
        .eff_addr (eff_addr)
    );

    sbc_array #(.AW(AW), .DW(DW)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (arr_wr),
        .rd_en (arr_rd),
        .addr  (eff_addr),
        .wdata (dq_in),
        .rdata (rd_data)
    );

    // Next-state and cycle controls
    always_comb begin
        in_burst = (state_q == ST_READ) || (state_q == ST_WRITE);
        load     = !sleep && start && sel;
        adv_go   = !sleep && !start && !adv_n && in_burst;
        hold_rd  = !sleep && !start && adv_n && (state_q == ST_READ);
        arr_wr   = (load || adv_go) && !we_n;
        arr_rd   = ((load || adv_go) && we_n) || hold_rd;
        state_nx = state_q;
        if (sleep) begin
            state_nx = ST_SLEEP;                                // doze
        end else if (start) begin
            if (sel) state_nx = we_n ? ST_READ : ST_WRITE;      // select-read / select-write
            else     state_nx = ST_DESEL;                       // deselect
        end else if (adv_go) begin
            state_nx = we_n ? ST_READ : ST_WRITE;               // advance-read / advance-write
        end else begin
            unique case (state_q)
                ST_SLEEP: state_nx = ST_DESEL;                  // wake
                ST_DESEL: state_nx = ST_DESEL;
                ST_READ:  state_nx = ST_READ;                   // suspend
                ST_WRITE: state_nx = ST_WRITE;                  // suspend
                default:  state_nx = ST_DESEL;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DESEL;
        else        state_q <= state_nx;
    end

    // Outputs: output enable acts without a clock, gated by the state
    always_comb begin
        dq_drive = (state_q == ST_READ) && !oe_n;
        dq_out   = dq_drive ? rd_data : '0;
    end

    // R8: output enable high always releases the bus
    a_r8_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive);
    // R8: nothing is driven while deselected, including the strobe cycle out of it
    a_r8_first_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DESEL) |-> !dq_drive);
    // R2: a strobe that finds the device deselected turns the output off
    a_r2_desel_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && start && !sel) |=> !dq_drive);
    // R3: an unqualified processor strobe alone leaves the state unchanged
    a_r3_proc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && cs1_n && !astb_p_n && astb_c_n && adv_n && state_q != ST_SLEEP)
            |=> state_q == $past(state_q));
    // R9: sleep forces the low-activity state and disables writes
    a_r9_doze: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state_q == ST_SLEEP && !dq_drive));
    a_r9_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !arr_wr);
endmodule

// File: tb/test_sram_burst_ctl.sv
module test_sram_burst_ctl;
    localparam int AW = 6;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs1_n, cs2, cs3_n, astb_p_n, astb_c_n, adv_n, we_n, oe_n, sleep;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_drive;
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    always #5 clk = ~clk;

    sram_burst_ctl #(.AW(AW), .DW(DW)) i_sram_burst_ctl (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .astb_p_n(astb_p_n), .astb_c_n(astb_c_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .sleep(sleep), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive)
    );

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 37 + 11);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        astb_p_n = 1'b1; astb_c_n = 1'b1; adv_n = 1'b1; we_n = 1'b1;
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0; sleep = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(); oe_n = 1'b0; addr = '0; dq_in = '0; rst_n = 1'b0;
        step();
        chk("R1 drive in reset", dq_drive, 0);
        chk("R1 data in reset", dq_out, 0);
        rst_n = 1'b1;
        step();
        chk("R1 drive after reset", dq_drive, 0);

        // R7: fill every word with four-word write bursts
        for (int b = 0; b < 16; b++) begin
            idle(); addr = AW'(b * 4); we_n = 1'b0; dq_in = pat(b * 4);
            if (b % 2 == 1) astb_p_n = 1'b0; else astb_c_n = 1'b0;
            step();
            chk("R8 no drive in write", dq_drive, 0);
            for (int k = 1; k < 4; k++) begin
                idle(); adv_n = 1'b0; we_n = 1'b0; dq_in = pat(b * 4 + k);
                step();
                chk("R7 write burst no drive", dq_drive, 0);
            end
        end

        // R4 / R6: read bursts from every base and every offset, with wrap
        for (int b = 0; b < 16; b++) begin
            for (int s = 0; s < 4; s++) begin
                idle(); addr = AW'(b * 4 + s);
                if (s % 2 == 1) astb_p_n = 1'b0; else astb_c_n = 1'b0;
                step();
                chk("R6 read drive", dq_drive, 1);
                chk("R6 read latency", dq_out, pat(b * 4 + s));
                for (int k = 1; k <= 4; k++) begin
                    idle(); adv_n = 1'b0;
                    step();
                    chk("R4 burst order", dq_out, pat(b * 4 + ((s + k) % 4)));
                end
            end
        end

        // R5: suspend holds the word
        idle(); addr = AW'(20); astb_c_n = 1'b0; step();
        idle(); step();
        chk("R5 hold 1", dq_out, pat(20));
        step();
        chk("R5 hold 2", dq_out, pat(20));
        idle(); adv_n = 1'b0; step();
        chk("R5 resume", dq_out, pat(21));

        // R8: output enable acts without a clock
        idle(); oe_n = 1'b1; #1;
        chk("R8 oe high drive", dq_drive, 0);
        chk("R8 oe high data", dq_out, 0);
        oe_n = 1'b0; #1;
        chk("R8 oe low drive", dq_drive, 1);
        chk("R8 oe low data", dq_out, pat(21));

        // R2: all chip-enable combinations
        for (int c = 0; c < 8; c++) begin
            idle();
            cs1_n = c[2]; cs2 = c[1]; cs3_n = c[0];
            astb_c_n = 1'b0; addr = AW'(33 + c);
            step();
            chk("R2 select decode", dq_drive, (c == 2) ? 1 : 0);
            if (c == 2) chk("R2 selected data", dq_out, pat(33 + c));
        end

        // R8: first strobe cycle out of deselect is blank
        idle(); cs2 = 1'b0; astb_c_n = 1'b0; step();
        chk("R8 deselected", dq_drive, 0);
        idle(); addr = AW'(40); astb_c_n = 1'b0; #1;
        chk("R8 strobe cycle blank", dq_drive, 0);
        step();
        chk("R8 first read drive", dq_drive, 1);
        chk("R8 first read data", dq_out, pat(40));

        // R3: processor strobe qualification and priority
        idle(); addr = AW'(12); astb_p_n = 1'b0; step();
        chk("R3 burst open", dq_out, pat(12));
        idle(); cs1_n = 1'b1; astb_p_n = 1'b0; adv_n = 1'b0; addr = AW'(50); step();
        chk("R3 ignored strobe drive", dq_drive, 1);
        chk("R3 ignored strobe advance", dq_out, pat(13));
        idle(); cs1_n = 1'b1; astb_p_n = 1'b0; astb_c_n = 1'b0; step();
        chk("R3 controller takes over", dq_drive, 0);
        idle(); astb_p_n = 1'b0; astb_c_n = 1'b0; addr = AW'(44); step();
        chk("R3 both strobes data", dq_out, pat(44));

        // R7: overwrite by strobe and by advance
        idle(); addr = AW'(10); astb_p_n = 1'b0; we_n = 1'b0; dq_in = 8'h5A; step();
        idle(); addr = AW'(10); astb_c_n = 1'b0; step();
        chk("R7 strobe write", dq_out, 8'h5A);
        idle(); adv_n = 1'b0; we_n = 1'b0; dq_in = 8'hC3; step();
        chk("R7 advance write no drive", dq_drive, 0);
        idle(); addr = AW'(11); astb_c_n = 1'b0; step();
        chk("R7 advance write", dq_out, 8'hC3);

        // R9: sleep ignores everything and keeps data
        idle(); addr = AW'(9); astb_c_n = 1'b0; step();
        chk("R9 before sleep", dq_out, pat(9));
        idle(); sleep = 1'b1; addr = AW'(9); astb_p_n = 1'b0; we_n = 1'b0; dq_in = 8'hEE; step();
        chk("R9 sleep drive", dq_drive, 0);
        for (int i = 0; i < 3; i++) begin
            idle(); sleep = 1'b1; adv_n = 1'b0; we_n = 1'b0; step();
            chk("R9 sleep hold", dq_drive, 0);
        end
        idle(); step();
        chk("R9 wake deselected", dq_drive, 0);
        idle(); addr = AW'(9); astb_c_n = 1'b0; step();
        chk("R9 data kept", dq_out, pat(9));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule